// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

This block drives the timing and amplitude codes for charge-balanced biphasic current stimulation on one electrode site at a time. A start request captures a site address, two 8-bit amplitude codes, the widths of the positive and negative phases, the gap between the two phases, the gap between successive pulses and a pulse count. From those values the block produces one pulse or a train of up to 31 pulses. Each pulse is a positive (anodic) phase, then an optional gap, then a negative (cathodic) phase. Downstream current DACs and electrode drivers take the phase select, the amplitude code and the site address.

All durations are counted in a coarse time unit of 34 master-clock cycles, which is 34 µs at a 1 MHz master clock. A unit prescaler produces this unit and restarts at every interval boundary. A separate discharge request ties the electrodes to ground to remove residual charge. The sequencer enters this grounding mode only while no stimulation is in progress.

Top module: `stim_pulse_seq`

## Requirements
- R1: After reset, `phase_o` is 2'b00, `amp_o` is 0, `site_o` is 0, and `gnd_en_o`, `busy_o` and `done_o` are all low.
- R2: When `start_i` is seen high at a clock edge while the sequencer is idle and `discharge_i` is low, the next cycle shows `phase_o` = 2'b01 (anodic) with `amp_o` = `amp_an_i`. This phase lasts max(`width_an_i`,1)×34 cycles.
- R3: After the anodic phase, `phase_o` is 2'b00 with `busy_o` high for `gap_ip_i`×34 cycles; a zero value skips this gap. Then `phase_o` is 2'b10 (cathodic) with `amp_o` = `amp_ca_i` for max(`width_ca_i`,1)×34 cycles.
- R4: `amp_o` is 0 in every cycle in which `phase_o` is neither 2'b01 nor 2'b10.
- R5: A train holds `reps_i` pulses, with a value of 0 treated as 1. Successive pulses are separated by `gap_pp_i`×34 cycles of `phase_o` = 2'b00 with `busy_o` high; a zero value skips this gap. In the cycle after the last cathodic phase, `done_o` is high for one cycle and `busy_o` is low.
- R6: When `discharge_i` is seen high at an edge while idle, `gnd_en_o` is high from the next cycle for as long as the request is held. It falls one cycle after the request is released. If a start request arrives in the same cycle, the discharge request takes precedence and the start is dropped.
- R7: `gnd_en_o` is never high while `busy_o` is high or while `phase_o` is nonzero. A discharge request made during a stimulation takes effect only once the sequencer is idle.
- R8: A start request made while the sequencer is busy or grounding is ignored. Input parameter changes made during a stimulation do not affect it.
- R9: `site_o` shows the site address captured at the accepted start and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Stimulation start request |
| discharge_i | input | 1 | Electrode grounding request (level) |
| site_i | input | 8 | Site address, row and column of a 16×16 array |
| amp_an_i | input | 8 | Anodic amplitude code |
| amp_ca_i | input | 8 | Cathodic amplitude code |
| width_an_i | input | 6 | Anodic width in time units |
| width_ca_i | input | 6 | Cathodic width in time units |
| gap_ip_i | input | 6 | Gap between the phases of one pulse, in time units |
| gap_pp_i | input | 6 | Gap between pulses, in time units |
| reps_i | input | 5 | Pulses per train |
| phase_o | output | 2 | 00 off, 01 anodic, 10 cathodic |
| amp_o | output | 8 | Amplitude code for the active phase |
| site_o | output | 8 | Site address of the current stimulation |
| gnd_en_o | output | 1 | Ties the electrodes to ground |
| busy_o | output | 1 | Stimulation in progress |
| done_o | output | 1 | One-cycle pulse at the end of a train |

## Verification
A corrupted unit prescaler or interval counter shows up as a phase boundary at the ports that is early or late. The per-cycle reference comparison catches it on the first wrong cycle, which is at most 34 cycles after the fault for the prescaler. A wrong pulse count or lost parameter capture shows as an extra or missing anodic phase, or as a misplaced `done_o`, by the end of the train. A fault in the state register that lets grounding and a stimulation phase overlap, or that accepts a start while busy, changes `gnd_en_o`, `phase_o` or `site_o` in the very next cycle.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANOD,
        ST_IPG,
        ST_CATH,
        ST_PPG,
        ST_GND
    } seq_state_e;

    localparam logic [1:0] PH_OFF  = 2'b00;
    localparam logic [1:0] PH_ANOD = 2'b01;
    localparam logic [1:0] PH_CATH = 2'b10;

endpackage

// File: rtl/stim_unit_timer.sv
module stim_unit_timer #(
    parameter int UNIT_CYC = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PRE_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYC - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    assign tick_o = (pre_q == PRE_LAST);

    always_comb begin
        if (clear_i || tick_o) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST); // R3

endmodule

// File: rtl/stim_pulse_seq.sv
module stim_pulse_seq
    import stim_seq_pkg::*;
#(
    parameter int UNIT_CYC = 34,
    parameter int CNT_W    = 6,
    parameter int AMP_W    = 8,
    parameter int SITE_W   = 8,
    parameter int REP_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              discharge_i,
    input  logic [SITE_W-1:0] site_i,
    input  logic [AMP_W-1:0]  amp_an_i,
    input  logic [AMP_W-1:0]  amp_ca_i,
    input  logic [CNT_W-1:0]  width_an_i,
    input  logic [CNT_W-1:0]  width_ca_i,
    input  logic [CNT_W-1:0]  gap_ip_i,
    input  logic [CNT_W-1:0]  gap_pp_i,
    input  logic [REP_W-1:0]  reps_i,
    output logic [1:0]        phase_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic [SITE_W-1:0] site_o,
    output logic              gnd_en_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] ONE_UNIT = CNT_W'(1);
    localparam logic [REP_W-1:0] ONE_REP  = REP_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  rem;
        logic [REP_W-1:0]  left;
        logic [SITE_W-1:0] site;
        logic [AMP_W-1:0]  amp_an;
        logic [AMP_W-1:0]  amp_ca;
        logic [CNT_W-1:0]  w_an;
        logic [CNT_W-1:0]  w_ca;
        logic [CNT_W-1:0]  g_ip;
        logic [CNT_W-1:0]  g_pp;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      load_d;
    logic      tick;
    logic      seg_end;
    logic      timer_clear;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE_UNIT : v;
    endfunction

    assign timer_clear = load_d || (r_q.st == ST_IDLE) || (r_q.st == ST_GND);

    stim_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clear),
        .tick_o  (tick)
    );

    assign seg_end = tick && (r_q.rem == ONE_UNIT);

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        load_d = 1'b0;
        if (tick && !seg_end && (r_q.st inside {ST_ANOD, ST_IPG, ST_CATH, ST_PPG}))
            r_d.rem = r_q.rem - 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (discharge_i) begin
                    r_d.st = ST_GND;
                end else if (start_i) begin
                    r_d.st     = ST_ANOD;
                    r_d.site   = site_i;
                    r_d.amp_an = amp_an_i;
                    r_d.amp_ca = amp_ca_i;
                    r_d.w_an   = at_least_one(width_an_i);
                    r_d.w_ca   = at_least_one(width_ca_i);
                    r_d.g_ip   = gap_ip_i;
                    r_d.g_pp   = gap_pp_i;
                    r_d.left   = (reps_i == '0) ? ONE_REP : reps_i;
                    r_d.rem    = at_least_one(width_an_i);
                    load_d     = 1'b1;
                end
            end
            ST_GND: begin
                if (!discharge_i) r_d.st = ST_IDLE;
            end
            ST_ANOD: begin
                if (seg_end) begin
                    load_d = 1'b1;
                    if (r_q.g_ip != '0) begin
                        r_d.st  = ST_IPG;
                        r_d.rem = r_q.g_ip;
                    end else begin
                        r_d.st  = ST_CATH;
                        r_d.rem = r_q.w_ca;
                    end
                end
            end
            ST_IPG: begin
                if (seg_end) begin
                    load_d  = 1'b1;
                    r_d.st  = ST_CATH;
                    r_d.rem = r_q.w_ca;
                end
            end
            ST_CATH: begin
                if (seg_end) begin
                    load_d = 1'b1;
                    if (r_q.left == ONE_REP) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                        if (r_q.g_pp != '0) begin
                            r_d.st  = ST_PPG;
                            r_d.rem = r_q.g_pp;
                        end else begin
                            r_d.st  = ST_ANOD;
                            r_d.rem = r_q.w_an;
                        end
                    end
                end
            end
            ST_PPG: begin
                if (seg_end) begin
                    load_d  = 1'b1;
                    r_d.st  = ST_ANOD;
                    r_d.rem = r_q.w_an;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        phase_o = PH_OFF;
        amp_o   = '0;
        if (r_q.st == ST_ANOD) begin
            phase_o = PH_ANOD;
            amp_o   = r_q.amp_an;
        end else if (r_q.st == ST_CATH) begin
            phase_o = PH_CATH;
            amp_o   = r_q.amp_ca;
        end
    end

    assign site_o   = r_q.site;
    assign gnd_en_o = (r_q.st == ST_GND);
    assign busy_o   = r_q.st inside {ST_ANOD, ST_IPG, ST_CATH, ST_PPG};
    assign done_o   = r_q.done;

    AST_GND_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        gnd_en_o |-> (phase_o == PH_OFF) && !busy_o); // R7

    AST_GND_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnd_en_o) |-> !$past(busy_o)); // R7

    AST_AMP_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_OFF) |-> (amp_o == '0)); // R4

    AST_DONE_AFTER_CATH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase_o) == PH_CATH) && !busy_o); // R5

    AST_SITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(site_o)); // R9

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_o)); // R2

endmodule

// File: tb/stim_pulse_seq_test.sv
`timescale 1ns/1ps
module stim_pulse_seq_test;
    localparam int UNIT = 34;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       discharge_i = 1'b0;
    logic [7:0] site_i = '0;
    logic [7:0] amp_an_i = '0;
    logic [7:0] amp_ca_i = '0;
    logic [5:0] width_an_i = '0;
    logic [5:0] width_ca_i = '0;
    logic [5:0] gap_ip_i = '0;
    logic [5:0] gap_pp_i = '0;
    logic [4:0] reps_i = '0;
    logic [1:0] phase_o;
    logic [7:0] amp_o;
    logic [7:0] site_o;
    logic       gnd_en_o;
    logic       busy_o;
    logic       done_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    stim_pulse_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .discharge_i(discharge_i),
        .site_i(site_i), .amp_an_i(amp_an_i), .amp_ca_i(amp_ca_i),
        .width_an_i(width_an_i), .width_ca_i(width_ca_i), .gap_ip_i(gap_ip_i),
        .gap_pp_i(gap_pp_i), .reps_i(reps_i), .phase_o(phase_o), .amp_o(amp_o),
        .site_o(site_o), .gnd_en_o(gnd_en_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    // Reference model: per-cycle entries [1:0] phase, [9:2] amp, [10] done, [11] busy
    int  seg_q[$];
    int  cur = 0;
    bit  mgnd = 1'b0;
    int  msite = 0;

    task automatic push_seg(input int ph, input int amp, input int units);
        for (int k = 0; k < units * UNIT; k++)
            seg_q.push_back((1 << 11) | (amp << 2) | ph);
    endtask

    task automatic build_train();
        int wa, wc, n;
        wa = (width_an_i == 0) ? 1 : int'(width_an_i);
        wc = (width_ca_i == 0) ? 1 : int'(width_ca_i);
        n  = (reps_i == 0) ? 1 : int'(reps_i);
        for (int p = 0; p < n; p++) begin
            push_seg(1, int'(amp_an_i), wa);
            push_seg(0, 0, int'(gap_ip_i));
            push_seg(2, int'(amp_ca_i), wc);
            if (p < n - 1) push_seg(0, 0, int'(gap_pp_i));
        end
        seg_q.push_back(1 << 10);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            seg_q.delete();
            cur = 0; mgnd = 1'b0; msite = 0;
        end else if (cur[11]) begin
            cur = seg_q.pop_front();
        end else if (mgnd) begin
            mgnd = discharge_i;
            cur = 0;
        end else if (discharge_i) begin
            mgnd = 1'b1;
            cur = 0;
        end else if (start_i) begin
            build_train();
            msite = int'(site_i);
            cur = seg_q.pop_front();
        end else begin
            cur = 0;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", "phase", int'(phase_o), 0);
            chk("R1", "amp", int'(amp_o), 0);
            chk("R1", "gnd", int'(gnd_en_o), 0);
            chk("R1", "busy", int'(busy_o), 0);
            chk("R1", "done", int'(done_o), 0);
            chk("R1", "site", int'(site_o), 0);
        end else begin
            chk((cur[1:0] == 2'b01) ? "R2" : "R3", "phase", int'(phase_o), cur[1:0]);
            chk("R4", "amp", int'(amp_o), (cur >> 2) & 8'hFF);
            chk((discharge_i && cur[11]) ? "R7" : "R6", "gnd", int'(gnd_en_o), int'(mgnd));
            chk("R8", "busy", int'(busy_o), cur[11]);
            chk("R5", "done", int'(done_o), cur[10]);
            chk("R9", "site", int'(site_o), msite);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_par(input int s, input int aa, input int ac, input int wa,
                           input int wc, input int gi, input int gp, input int rp);
        @(negedge clk); #2;
        site_i = 8'(s); amp_an_i = 8'(aa); amp_ca_i = 8'(ac);
        width_an_i = 6'(wa); width_ca_i = 6'(wc); gap_ip_i = 6'(gi);
        gap_pp_i = 6'(gp); reps_i = 5'(rp);
    endtask

    task automatic pulse_start();
        @(negedge clk); #2 start_i = 1'b1;
        @(negedge clk); #2 start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        wait_cyc(3);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        #2 rst_n = 1'b1;
        wait_cyc(3);
        // R2 R3: single pulse with all intervals
        set_par(8'h35, 200, 150, 2, 3, 1, 0, 1);
        pulse_start();
        wait_idle();
        // R3 zero gap skipped, zero widths raised to one unit
        set_par(8'hF0, 17, 99, 0, 0, 0, 0, 1);
        pulse_start();
        wait_idle();
        // R5 R8 train, with a start and parameter change while busy
        set_par(8'h12, 60, 61, 1, 1, 0, 2, 3);
        pulse_start();
        wait_cyc(50);
        set_par(8'hAA, 5, 6, 7, 7, 7, 7, 7);
        pulse_start();
        // R7 discharge while busy deferred until idle
        wait_cyc(100);
        @(negedge clk); #2 discharge_i = 1'b1;
        wait_idle();
        wait_cyc(10);
        @(negedge clk); #2 discharge_i = 1'b0;
        wait_cyc(5);
        // R6 discharge wins over a simultaneous start
        set_par(8'h0F, 40, 41, 1, 1, 0, 0, 1);
        @(negedge clk); #2 begin discharge_i = 1'b1; start_i = 1'b1; end
        @(negedge clk); #2 start_i = 1'b0;
        wait_cyc(8);
        pulse_start();
        @(negedge clk); #2 discharge_i = 1'b0;
        wait_cyc(5);
        // R5 zero pulse count acts as one, then back-to-back start after done
        set_par(8'h21, 9, 10, 1, 2, 1, 1, 0);
        pulse_start();
        while (!done_o) @(negedge clk);
        #2 start_i = 1'b1;
        set_par(8'h22, 11, 12, 1, 1, 0, 0, 2);
        @(negedge clk); #2 start_i = 1'b0;
        wait_idle();
        // R5 longest train with minimal widths
        set_par(8'h7E, 255, 1, 1, 1, 0, 0, 31);
        pulse_start();
        wait_idle();
        // R2 R3 widest phases and gap
        set_par(8'hFF, 128, 129, 63, 63, 63, 0, 1);
        pulse_start();
        wait_idle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule